// File: doc/BRIEF.md
# AES Row Byte Substitution Unit

This block applies the AES byte substitution, or its inverse, to one row of four state bytes per request. Every byte is replaced by an entry from a 256-entry, 8-bit table. The table contents are constants computed at elaboration from the field arithmetic. They are held in synchronous lookup memories, which have registered outputs and no combinational read path. This is the structure that maps onto on-chip block memory.

A round controller presents a row on `row_i`, selects the direction on `inv_i`, and pulses `start_i`. The block registers the lookup address on the accepting clock edge, so the substituted row is ready when the controller needs it.

The `SERIAL` parameter picks one of two builds:
- **Parallel build (`SERIAL` = 0).** Two dual-port tables provide four read ports. A row is accepted every cycle and each result follows one cycle later, so a sequencer that advances one state per clock is never stalled.
- **Serial build (`SERIAL` = 1).** A single read port handles one byte per cycle. A row takes four cycles, and `busy_o` tells the sequencer to hold its state until `valid_o` arrives.

Flow control on the input side is carried by `start_i` and `busy_o`. A request counts as accepted only on a clock edge where `start_i` is high and `busy_o` is low. A start that is offered while busy is dropped, not queued. The output side has no back-pressure. `valid_o` is a single-cycle strobe, and `row_o` keeps its value afterwards until the next request is accepted.

Top module: `aes_sub_row`

## Requirements
- R1: With `inv_i` = 0, each output byte equals the forward S-box of its input byte. The whole byte is the table index: high nibble as row, low nibble as column. The forward S-box of x is the affine map (each bit of the inverse XOR its four left rotations, then XOR 0x63) applied to the multiplicative inverse of x in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapped to 0. Examples: 0x00 gives 0x63, 0x01 gives 0x7C, 0x53 gives 0xED, 0xFF gives 0x16.
- R2: With `inv_i` = 1, each output byte is the inverse S-box of its input byte. Feeding a forward result back in this direction returns the original byte, for all 256 values.
- R3: Byte k of the row occupies bits [8k+7:8k] of both `row_i` and `row_o`. Each byte lane is substituted independently.
- R4: `inv_i` and `row_i` are sampled only on the edge that accepts a start. Changing them afterwards does not alter the pending result.
- R5: Parallel build: `valid_o` is high in the cycle after each cycle in which `start_i` is high, and low otherwise. Starts on consecutive cycles give results on consecutive cycles. `busy_o` stays low.
- R6: Serial build: after an accepted start, `busy_o` is high for three cycles. `valid_o` pulses for exactly one cycle, four cycles after the start, in a cycle where `busy_o` is already low.
- R7: Serial build: a start while `busy_o` is high is ignored. It produces no extra `valid_o` pulse and does not change the result of the operation in progress.
- R8: In a cycle where no start is accepted and the block is not busy, `row_o` keeps its value into the next cycle.
- R9: A synchronous active-high `rst` clears `row_o` to zero and drives `valid_o` and `busy_o` low, even if `start_i` is high. The table contents are not affected: a lookup after reset returns correct values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request strobe; accepted when `busy_o` is low |
| inv_i | input | 1 | Direction: 0 forward table, 1 inverse table |
| row_i | input | NUM_BYTES*8 | Row bytes, byte k at [8k+7:8k] |
| row_o | output | NUM_BYTES*8 | Substituted row, same byte layout |
| valid_o | output | 1 | One-cycle strobe marking a fresh `row_o` |
| busy_o | output | 1 | Serial build: operation in progress; always 0 in parallel build |

## Verification
The hardest situations to reach from the ports are inside the serial build's busy window. One is a second request arriving while the single read port is still stepping through bytes. The other is the direction or row inputs moving after the start has already been taken. The bench holds `start_i` high with a different row for the whole window, or flips `inv_i` and scrambles `row_i` on the cycle after acceptance. It then confirms that only one strobe appears and that it carries the first row's result. In the parallel build, a full back-to-back sweep of all 256 byte values in both directions tests the pipelined address timing at full throughput.

// File: rtl/aes_sub_pkg.sv
package aes_sub_pkg;

  localparam int BYTE_W   = 8;
  localparam int ENTRIES  = 1 << BYTE_W;
  // Table address is {direction, byte}: forward half first, inverse half second.
  localparam int ADDR_W   = BYTE_W + 1;
  localparam int TBL_BITS = 2 * ENTRIES * BYTE_W;

  localparam logic [BYTE_W-1:0] AFFINE_C = 8'h63;
  localparam logic [BYTE_W-1:0] POLY_LO  = 8'h1b;

  typedef logic [BYTE_W-1:0] byte_t;

  // Multiplication in GF(2^8) modulo x^8+x^4+x^3+x+1.
  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t x;
    acc = '0;
    x   = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[BYTE_W-1] ? ((x << 1) ^ POLY_LO) : (x << 1);
    end
    return acc;
  endfunction

  // Inverse as a^254; zero maps to zero.
  function automatic byte_t gf_inv(input byte_t a);
    byte_t p;
    byte_t r;
    p = a;
    r = 8'h01;
    for (int k = 1; k < BYTE_W; k++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic byte_t rotl(input byte_t v, input int n);
    return byte_t'((v << n) | (v >> (BYTE_W - n)));
  endfunction

  function automatic byte_t sub_fwd(input byte_t b);
    byte_t s;
    byte_t y;
    s = gf_inv(b);
    y = s ^ AFFINE_C;
    for (int n = 1; n <= 4; n++) y = y ^ rotl(s, n);
    return y;
  endfunction

  // Both tables in one packed constant; the inverse half is filled by inverting the forward map.
  function automatic logic [TBL_BITS-1:0] build_table();
    logic [TBL_BITS-1:0] t;
    byte_t s;
    t = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      s = sub_fwd(byte_t'(i));
      t[i*BYTE_W +: BYTE_W] = s;
      t[(ENTRIES + int'(s))*BYTE_W +: BYTE_W] = byte_t'(i);
    end
    return t;
  endfunction

endpackage

// File: rtl/aes_sub_rom.sv
module aes_sub_rom
  import aes_sub_pkg::*;
#(
  parameter int PORTS = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [PORTS-1:0]               en,
  input  logic [PORTS-1:0][ADDR_W-1:0]   addr,
  output logic [PORTS-1:0][BYTE_W-1:0]   q
);

  localparam logic [TBL_BITS-1:0] TABLE = build_table();

  // Registered read on every port; the output holds while the port is idle.
  always_ff @(posedge clk) begin
    for (int p = 0; p < PORTS; p++) begin
      if (rst)        q[p] <= '0;
      else if (en[p]) q[p] <= TABLE[int'(addr[p])*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/aes_sub_par.sv
module aes_sub_par
  import aes_sub_pkg::*;
#(
  parameter int NUM_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_i,
  input  logic                          inv_i,
  input  logic [NUM_BYTES*BYTE_W-1:0]   row_i,
  output logic [NUM_BYTES*BYTE_W-1:0]   row_o,
  output logic                          valid_o
);

  localparam int LANES_PER_ROM = 2;
  localparam int NUM_ROMS      = NUM_BYTES / LANES_PER_ROM;
  localparam int SLICE_W       = LANES_PER_ROM * BYTE_W;

  for (genvar r = 0; r < NUM_ROMS; r++) begin : g_rom
    logic [LANES_PER_ROM-1:0][ADDR_W-1:0] rd_addr;
    logic [LANES_PER_ROM-1:0][BYTE_W-1:0] rd_q;

    for (genvar l = 0; l < LANES_PER_ROM; l++) begin : g_lane
      assign rd_addr[l] = {inv_i, row_i[(r*LANES_PER_ROM + l)*BYTE_W +: BYTE_W]};
    end

    aes_sub_rom #(.PORTS(LANES_PER_ROM)) u_rom (
      .clk  (clk),
      .rst  (rst),
      .en   ({LANES_PER_ROM{start_i}}),
      .addr (rd_addr),
      .q    (rd_q)
    );

    assign row_o[r*SLICE_W +: SLICE_W] = rd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_o <= 1'b0;
    else     valid_o <= start_i;
  end

endmodule

// File: rtl/aes_sub_ser.sv
module aes_sub_ser
  import aes_sub_pkg::*;
#(
  parameter int NUM_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_i,
  input  logic                          inv_i,
  input  logic [NUM_BYTES*BYTE_W-1:0]   row_i,
  output logic [NUM_BYTES*BYTE_W-1:0]   row_o,
  output logic                          valid_o,
  output logic                          busy_o
);

  localparam int ROW_W  = NUM_BYTES * BYTE_W;
  localparam int COLL_W = (NUM_BYTES - 1) * BYTE_W;
  localparam int CNT_W  = $clog2(NUM_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_BYTES - 1);

  logic                  busy_q;
  logic                  dir_q;
  logic                  valid_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [ROW_W-1:0]      row_q;
  logic [COLL_W-1:0]     coll_q;
  logic [BYTE_W-1:0]     rd_byte;
  logic                  rd_dir;
  logic [0:0][ADDR_W-1:0] rd_addr;
  logic [0:0][BYTE_W-1:0] rd_q;

  // When idle, byte 0 is addressed straight from the request; later bytes come from the latched row.
  assign rd_byte    = busy_q ? row_q[int'(cnt_q)*BYTE_W +: BYTE_W] : row_i[BYTE_W-1:0];
  assign rd_dir     = busy_q ? dir_q : inv_i;
  assign rd_addr[0] = {rd_dir, rd_byte};

  aes_sub_rom #(.PORTS(1)) u_rom (
    .clk  (clk),
    .rst  (rst),
    .en   (busy_q | start_i),
    .addr (rd_addr),
    .q    (rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      dir_q   <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
      row_q   <= '0;
      coll_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_W'(1);
          dir_q  <= inv_i;
          row_q  <= row_i;
        end
      end else begin
        // Capture the byte read on the previous edge while addressing the next one.
        coll_q[(int'(cnt_q) - 1)*BYTE_W +: BYTE_W] <= rd_q[0];
        if (cnt_q == LAST) begin
          busy_q  <= 1'b0;
          valid_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // The last byte is taken from the table output, which holds until the next accepted start.
  assign row_o   = {rd_q[0], coll_q};
  assign valid_o = valid_q;
  assign busy_o  = busy_q;

endmodule

// File: rtl/aes_sub_row.sv
module aes_sub_row
  import aes_sub_pkg::*;
#(
  parameter bit SERIAL    = 1'b0,
  parameter int NUM_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_i,
  input  logic                          inv_i,
  input  logic [NUM_BYTES*BYTE_W-1:0]   row_i,
  output logic [NUM_BYTES*BYTE_W-1:0]   row_o,
  output logic                          valid_o,
  output logic                          busy_o
);

  if (SERIAL) begin : g_serial
    aes_sub_ser #(.NUM_BYTES(NUM_BYTES)) u_ser (
      .clk     (clk),
      .rst     (rst),
      .start_i (start_i),
      .inv_i   (inv_i),
      .row_i   (row_i),
      .row_o   (row_o),
      .valid_o (valid_o),
      .busy_o  (busy_o)
    );
  end else begin : g_parallel
    aes_sub_par #(.NUM_BYTES(NUM_BYTES)) u_par (
      .clk     (clk),
      .rst     (rst),
      .start_i (start_i),
      .inv_i   (inv_i),
      .row_i   (row_i),
      .row_o   (row_o),
      .valid_o (valid_o)
    );
    assign busy_o = 1'b0;
  end

endmodule

// File: rtl/aes_sub_row_chk.sv
module aes_sub_row_chk #(
  parameter bit SERIAL    = 1'b0,
  parameter int NUM_BYTES = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     start_i,
  input logic [NUM_BYTES*8-1:0]   row_o,
  input logic                     valid_o,
  input logic                     busy_o
);

  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (row_o == '0 && !valid_o && !busy_o));

  a_r8_row_hold: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !busy_o) |=> $stable(row_o));

  if (!SERIAL) begin : g_par
    a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
      start_i |=> valid_o);
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !start_i |=> !valid_o);
    a_r5_never_busy: assert property (@(posedge clk) disable iff (rst)
      !busy_o);
  end else begin : g_ser
    localparam int AGE_W = 8;
    logic             pend;
    logic [AGE_W-1:0] age;

    // Cycles elapsed since the last accepted start.
    always_ff @(posedge clk) begin
      if (rst) begin
        pend <= 1'b0;
        age  <= '0;
      end else if (start_i && !busy_o) begin
        pend <= 1'b1;
        age  <= AGE_W'(1);
      end else if (pend) begin
        if (age == AGE_W'(NUM_BYTES)) pend <= 1'b0;
        age <= age + AGE_W'(1);
      end
    end

    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
      (pend && age == AGE_W'(NUM_BYTES)) |-> valid_o);
    a_r7_no_extra_valid: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> (pend && age == AGE_W'(NUM_BYTES)));
    a_r6_busy_on_accept: assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy_o) |=> busy_o);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);
    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> !busy_o);
  end

endmodule

bind aes_sub_row aes_sub_row_chk #(.SERIAL(SERIAL), .NUM_BYTES(NUM_BYTES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .row_o   (row_o),
  .valid_o (valid_o),
  .busy_o  (busy_o)
);

// File: tb/aes_sub_row_test.sv
`timescale 1ns/100ps
module aes_sub_row_test;

  localparam int NB = 4;
  localparam int RW = NB * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          p_start = 1'b0, p_inv = 1'b0;
  logic [RW-1:0] p_row = '0, p_out;
  logic          p_valid, p_busy;
  logic          s_start = 1'b0, s_inv = 1'b0;
  logic [RW-1:0] s_row = '0, s_out;
  logic          s_valid, s_busy;

  aes_sub_row #(.SERIAL(1'b0), .NUM_BYTES(NB)) uut (
    .clk(clk), .rst(rst), .start_i(p_start), .inv_i(p_inv), .row_i(p_row),
    .row_o(p_out), .valid_o(p_valid), .busy_o(p_busy));

  aes_sub_row #(.SERIAL(1'b1), .NUM_BYTES(NB)) uut_ser (
    .clk(clk), .rst(rst), .start_i(s_start), .inv_i(s_inv), .row_i(s_row),
    .row_o(s_out), .valid_o(s_valid), .busy_o(s_busy));

  int n_run  = 0;
  int n_fail = 0;
  logic [7:0] rf [256];
  logic [7:0] ri [256];

  // Reference model: peasant multiply, brute-force inverse, bitwise affine form.
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] x;
    logic [7:0] acc;
    logic [7:0] y;
    x = {1'b0, a};
    y = b;
    acc = '0;
    while (y != 0) begin
      if (y[0]) acc = acc ^ x[7:0];
      x = x << 1;
      if (x[8]) x = x ^ 9'h11b;
      y = y >> 1;
    end
    return acc;
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] v);
    logic [7:0] inv;
    logic [7:0] o;
    inv = '0;
    for (int c = 1; c < 256; c++)
      if (ref_mul(v, 8'(c)) == 8'h01) inv = 8'(c);
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ (8'h63 >> i) & 1'b1;
    return o;
  endfunction

  task automatic check(input string req, input string what, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    p_start = 1'b1; s_start = 1'b1;
    repeat (3) @(negedge clk);
    p_start = 1'b0; s_start = 1'b0;
    rst = 1'b0;
    check("R9", "par row after reset", p_out, '0);
    check("R9", "par valid after reset", RW'(p_valid), '0);
    check("R9", "ser row after reset", s_out, '0);
    check("R9", "ser valid/busy after reset", RW'({s_valid, s_busy}), '0);
  endtask

  task automatic t_par_known();
    @(negedge clk);
    p_row = 32'hff_53_01_00; p_inv = 1'b0; p_start = 1'b1;
    @(negedge clk);
    p_start = 1'b0;
    check("R1 R3", "known forward row", p_out, 32'h16_ed_7c_63);
    p_row = 32'h16_ed_7c_63; p_inv = 1'b1; p_start = 1'b1;
    @(negedge clk);
    p_start = 1'b0;
    check("R2 R3", "known inverse row", p_out, 32'hff_53_01_00);
  endtask

  // mode 0: forward sweep, 1: inverse sweep, 2: inverse of forward values
  task automatic t_par_stream(input int mode);
    logic [RW-1:0] exp_q;
    logic [RW-1:0] exp_n;
    string req;
    req = (mode == 0) ? "R1 R5" : "R2 R5";
    exp_q = '0;
    for (int k = 0; k <= 64; k++) begin
      @(negedge clk);
      if (k > 0) begin
        check(req, "stream valid", RW'(p_valid), RW'(1));
        check(req, "stream row", p_out, exp_q);
      end
      if (k < 64) begin
        for (int j = 0; j < NB; j++) begin
          case (mode)
            0: begin p_row[8*j +: 8] = 8'(4*k+j);     exp_n[8*j +: 8] = rf[4*k+j]; end
            1: begin p_row[8*j +: 8] = 8'(4*k+j);     exp_n[8*j +: 8] = ri[4*k+j]; end
            default: begin p_row[8*j +: 8] = rf[4*k+j]; exp_n[8*j +: 8] = 8'(4*k+j); end
          endcase
        end
        p_inv = (mode != 0);
        p_start = 1'b1;
        exp_q = exp_n;
      end else begin
        p_start = 1'b0;
      end
    end
    @(negedge clk);
    check("R5", "idle valid low", RW'(p_valid), '0);
    check("R5", "busy always low", RW'(p_busy), '0);
    check("R8", "row held while idle", p_out, exp_q);
    p_row = ~p_row; p_inv = ~p_inv;
    @(negedge clk);
    check("R8", "row held with inputs moving", p_out, exp_q);
  endtask

  task automatic t_ser_row(input logic [RW-1:0] row, input logic inv, input logic [RW-1:0] exp, input logic disturb);
    @(negedge clk);
    s_row = row; s_inv = inv; s_start = 1'b1;
    for (int c = 1; c <= 5; c++) begin
      @(negedge clk);
      if (c == 1) begin
        s_start = 1'b0;
        if (disturb) begin s_inv = ~inv; s_row = ~row; end
      end
      if (c < 4) begin
        check("R6", "busy during op", RW'(s_busy), RW'(1));
        check("R6", "no early valid", RW'(s_valid), '0);
      end else if (c == 4) begin
        check("R6", "valid at cycle 4", RW'(s_valid), RW'(1));
        check("R6", "busy clear at done", RW'(s_busy), '0);
        check(disturb ? "R4" : "R1 R2 R3", "serial row", s_out, exp);
      end else begin
        check("R6", "valid single pulse", RW'(s_valid), '0);
        check("R8", "serial row held", s_out, exp);
      end
    end
  endtask

  task automatic t_ser_sweep();
    logic [RW-1:0] r;
    logic [RW-1:0] e;
    for (int k = 0; k < 64; k += 9) begin
      for (int j = 0; j < NB; j++) begin r[8*j +: 8] = 8'(4*k+j); e[8*j +: 8] = rf[4*k+j]; end
      t_ser_row(r, 1'b0, e, 1'b0);
      t_ser_row(e, 1'b1, r, 1'b0);
    end
  endtask

  task automatic t_ser_ignore();
    logic [RW-1:0] a;
    logic [RW-1:0] ea;
    a = 32'h10_32_54_76;
    for (int j = 0; j < NB; j++) ea[8*j +: 8] = rf[a[8*j +: 8]];
    @(negedge clk);
    s_row = a; s_inv = 1'b0; s_start = 1'b1;
    @(negedge clk);
    s_row = 32'hde_ad_be_ef; s_inv = 1'b1;
    repeat (3) @(negedge clk);
    s_start = 1'b0;
    check("R7", "first result kept", s_out, ea);
    check("R7", "one valid", RW'(s_valid), RW'(1));
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check("R7", "no extra valid", RW'(s_valid), '0);
    end
    check("R7", "result unchanged", s_out, ea);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    s_row = 32'h01_02_03_04; s_inv = 1'b0; s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9", "mid-op reset row", s_out, '0);
    check("R9", "mid-op reset flags", RW'({s_valid, s_busy}), '0);
    repeat (6) @(negedge clk);
    check("R9", "no valid after reset", RW'(s_valid), '0);
    t_ser_row(32'hff_53_01_00, 1'b0, 32'h16_ed_7c_63, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) rf[i] = ref_sbox(8'(i));
    for (int i = 0; i < 256; i++) ri[rf[i]] = 8'(i);
    t_reset();
    t_par_known();
    t_par_stream(0);
    t_par_stream(1);
    t_par_stream(2);
    t_ser_sweep();
    t_ser_row(32'hff_53_01_00, 1'b0, 32'h16_ed_7c_63, 1'b1);
    t_ser_ignore();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule